// File: doc/BRIEF.md
# Vectored Interrupt Router

The block gathers a parameterised number of device interrupt inputs (256 by default) and routes each one to the local cores and parent interrupt lines. A rising edge on an input marks that vector pending. Delivery happens while the vector is enabled and the global enable is on. A per-vector route byte then picks the cores that receive it and the node that owns it. The vector's bit is set in a private status word of each chosen core. A per-group map byte chooses which of that core's parent lines the status bit raises. Software acknowledges a vector by writing back, to a core's status word, the bits it has read.

A vector whose route names another node is not delivered locally. The block exports it as a one-cycle remote strobe that carries the destination node and the vector number. Software reroutes a vector safely in three steps: mask it, rewrite its route byte, then unmask it. A vector that is pending while masked waits and is delivered under the new route.

Top module: `vec_irq_router`

## Requirements
- R1: After reset the control word, all enable and bounce words and all status words read 0, and `irq_lines` and `remote_vld` are low. Every map byte reads 0x02, which selects line 1. Every route byte reads `{LOCAL_NODE[3:0], 4'b0001}`, which selects core 0 on the local node.
- R2: The register port uses word addresses, with regions laid out back to back in this order: control (1 word), map (ceil(N_VEC/128) words), enable (N_VEC/32), bounce (N_VEC/32), route (N_VEC/4), and status (N_VEC/32 words per core, cores in ascending order). A write changes only the bytes whose `reg_wstrb` lane is set. Map bytes beyond the last group always read 0.
- R3: A rising edge on `vec_in[v]` makes the vector pending. With no masking, status bit v%32 of status word v/32 of each target core is set on the second clock edge after the edge is sampled. A level held high does not pend the vector again.
- R4: In route byte v%4 of route word v/4, bits [3:0] are a core bitmap and bits [7:4] are a node number. With bounce bit 0, a local vector is delivered to every core named in the bitmap.
- R5: With bounce bit v set (bit v%32 of bounce word v/32), a local vector is delivered only to the lowest-numbered core in its bitmap.
- R6: A vector whose enable bit is 0 (bit v%32 of enable word v/32), or any vector while control bit 0 is 0, is not delivered and stays pending. When it is unmasked, it is delivered under the route in force at that time.
- R7: A vector routed to the local node with an empty core bitmap stays pending until a later route names a core.
- R8: A pending, enabled vector whose route node differs from `LOCAL_NODE` sets no status bit. It raises `remote_vld` for one cycle, with `remote_node` and `remote_vec`. When several such vectors wait, one is sent per cycle, the lowest vector number first.
- R9: Writing 1 to a status bit clears it. When a delivery sets the same bit on the same clock edge, the set takes effect.
- R10: `irq_lines[c*N_LINE+k]` is high exactly when the global enable is on and core c holds a status bit for an enabled vector whose group map byte (byte g%4 of map word g/4, g = v/32) has bit k set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | N_VEC | Device interrupt inputs, rising-edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_lines | output | N_CORE*N_LINE | Parent interrupt lines, core-major |
| remote_vld | output | 1 | Remote delivery strobe |
| remote_node | output | 4 | Destination node of the strobed vector |
| remote_vec | output | $clog2(N_VEC) | Vector number of the strobed vector |

## Verification
A software acknowledge of a core's status word can land on the same clock edge as a fresh delivery of one of the bits being cleared. The bench provokes this by timing a second edge of a vector so that its delivery edge is exactly the edge on which a write-back clears that vector together with another bit. It then expects the re-delivered bit to survive, the other bit to be gone, and the parent line to stay raised. The bench also sweeps every vector of a 64-vector configuration through its own route and bounce pattern, and checks each core's status word and lines against values it computes from the route arithmetic.

// File: rtl/vir_pkg.sv
package vir_pkg;
   localparam int LANE_W   = 8;
   localparam int WORD_W   = 32;
   localparam int LANES    = WORD_W / LANE_W;
   localparam int GRP_SZ   = 32;
   localparam int MAX_CORE = 4;
   localparam int MAX_LINE = 8;

   typedef struct packed {
      logic [3:0] node;
      logic [3:0] cores;
   } route_t;

   function automatic int ceil_div(int a, int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/vir_regs.sv
module vir_regs
   import vir_pkg::*;
#(
   parameter int N_VEC      = 256,
   parameter int N_CORE     = 4,
   parameter int LOCAL_NODE = 0,
   parameter int RST_LINE   = 1,
   parameter int ADDR_W     = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [WORD_W-1:0]         reg_wdata,
   input  logic [LANES-1:0]          reg_wstrb,
   output logic [WORD_W-1:0]         reg_rdata,
   input  logic [N_CORE*N_VEC-1:0]   st_flat,
   output logic [N_CORE*N_VEC-1:0]   clr_flat,
   output logic                      gen_en,
   output logic [N_VEC-1:0]          en_vec,
   output logic [N_VEC-1:0]          bnc_vec,
   output logic [N_VEC*LANE_W-1:0]   route_flat,
   output logic [(N_VEC/GRP_SZ)*LANE_W-1:0] pmap_flat
);
   localparam int N_GRP   = N_VEC / GRP_SZ;
   localparam int N_PMW   = ceil_div(N_GRP, LANES);
   localparam int N_RTW   = N_VEC / LANES;
   localparam int CTRL_A  = 0;
   localparam int PMAP_A  = CTRL_A + 1;
   localparam int EN_A    = PMAP_A + N_PMW;
   localparam int BNC_A   = EN_A + N_GRP;
   localparam int RT_A    = BNC_A + N_GRP;
   localparam int ST_A    = RT_A + N_RTW;
   localparam int END_A   = ST_A + N_CORE * N_GRP;
   localparam int PM_BYTES = N_PMW * LANES;
   localparam logic [PM_BYTES-1:0] PM_LIVE = {PM_BYTES{1'b1}} >> (PM_BYTES - N_GRP);
   localparam logic [LANE_W-1:0] RST_PMAP  = LANE_W'(1 << RST_LINE);
   localparam logic [LANE_W-1:0] RST_ROUTE = {4'(LOCAL_NODE), 4'b0001};

   if (ADDR_W < $clog2(END_A)) begin : g_bad_addr
      $error("vir_regs: ADDR_W too small for the register map");
   end

   logic [N_PMW*WORD_W-1:0] pmap_reg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_en   <= 1'b0;
         en_vec   <= '0;
         bnc_vec  <= '0;
         for (int g = 0; g < PM_BYTES; g++)
            pmap_reg[g*LANE_W +: LANE_W] <= PM_LIVE[g] ? RST_PMAP : '0;
         for (int v = 0; v < N_VEC; v++)
            route_flat[v*LANE_W +: LANE_W] <= RST_ROUTE;
      end else if (reg_wr) begin
         for (int b = 0; b < LANES; b++) begin
            if (reg_wstrb[b]) begin
               if (b == 0 && reg_addr == ADDR_W'(CTRL_A))
                  gen_en <= reg_wdata[0];
               for (int w = 0; w < N_PMW; w++)
                  if (reg_addr == ADDR_W'(PMAP_A + w))
                     pmap_reg[(w*LANES+b)*LANE_W +: LANE_W] <=
                        reg_wdata[b*LANE_W +: LANE_W] & {LANE_W{PM_LIVE[w*LANES+b]}};
               for (int g = 0; g < N_GRP; g++) begin
                  if (reg_addr == ADDR_W'(EN_A + g))
                     en_vec[g*WORD_W + b*LANE_W +: LANE_W] <= reg_wdata[b*LANE_W +: LANE_W];
                  if (reg_addr == ADDR_W'(BNC_A + g))
                     bnc_vec[g*WORD_W + b*LANE_W +: LANE_W] <= reg_wdata[b*LANE_W +: LANE_W];
               end
               for (int w = 0; w < N_RTW; w++)
                  if (reg_addr == ADDR_W'(RT_A + w))
                     route_flat[(w*LANES+b)*LANE_W +: LANE_W] <= reg_wdata[b*LANE_W +: LANE_W];
            end
         end
      end
   end

   assign pmap_flat = pmap_reg[N_GRP*LANE_W-1:0];

   always_comb begin
      clr_flat = '0;
      if (reg_wr) begin
         for (int c = 0; c < N_CORE; c++)
            for (int g = 0; g < N_GRP; g++)
               for (int b = 0; b < LANES; b++)
                  if (reg_wstrb[b] && reg_addr == ADDR_W'(ST_A + c*N_GRP + g))
                     clr_flat[c*N_VEC + g*WORD_W + b*LANE_W +: LANE_W] =
                        reg_wdata[b*LANE_W +: LANE_W];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(CTRL_A))
         reg_rdata[0] = gen_en;
      for (int w = 0; w < N_PMW; w++)
         if (reg_addr == ADDR_W'(PMAP_A + w))
            reg_rdata = pmap_reg[w*WORD_W +: WORD_W];
      for (int g = 0; g < N_GRP; g++) begin
         if (reg_addr == ADDR_W'(EN_A + g))
            reg_rdata = en_vec[g*WORD_W +: WORD_W];
         if (reg_addr == ADDR_W'(BNC_A + g))
            reg_rdata = bnc_vec[g*WORD_W +: WORD_W];
      end
      for (int w = 0; w < N_RTW; w++)
         if (reg_addr == ADDR_W'(RT_A + w))
            reg_rdata = route_flat[w*WORD_W +: WORD_W];
      for (int c = 0; c < N_CORE; c++)
         for (int g = 0; g < N_GRP; g++)
            if (reg_addr == ADDR_W'(ST_A + c*N_GRP + g))
               reg_rdata = st_flat[c*N_VEC + g*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/vir_deliver.sv
module vir_deliver
   import vir_pkg::*;
#(
   parameter int N_VEC      = 256,
   parameter int N_CORE     = 4,
   parameter int LOCAL_NODE = 0,
   localparam int VEC_W     = $clog2(N_VEC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_VEC-1:0]          vec_in,
   input  logic                      gen_en,
   input  logic [N_VEC-1:0]          en_vec,
   input  logic [N_VEC-1:0]          bnc_vec,
   input  logic [N_VEC*LANE_W-1:0]   route_flat,
   output logic [N_CORE*N_VEC-1:0]   set_flat,
   output logic [N_VEC-1:0]          pend,
   output logic                      remote_vld,
   output logic [3:0]                remote_node,
   output logic [VEC_W-1:0]          remote_vec
);
   localparam logic [3:0] CORE_MASK = 4'((1 << N_CORE) - 1);

   logic [N_VEC-1:0] vec_q;
   logic [N_VEC-1:0] go_loc;
   logic [N_VEC-1:0] rem_req;
   logic [N_VEC-1:0] rem_clr;
   logic [VEC_W-1:0] win;
   logic             any_rem;

   always_comb begin
      route_t     rb;
      logic [3:0] bmp;
      logic [3:0] tgt;
      logic       live;
      set_flat = '0;
      go_loc   = '0;
      rem_req  = '0;
      for (int v = 0; v < N_VEC; v++) begin
         rb   = route_t'(route_flat[v*LANE_W +: LANE_W]);
         live = gen_en & en_vec[v] & pend[v];
         bmp  = rb.cores & CORE_MASK;
         tgt  = bnc_vec[v] ? (bmp & (~bmp + 4'd1)) : bmp;
         if (rb.node == 4'(LOCAL_NODE)) begin
            go_loc[v] = live && (bmp != 4'd0);
            for (int c = 0; c < N_CORE; c++)
               set_flat[c*N_VEC + v] = go_loc[v] & tgt[c];
         end else begin
            rem_req[v] = live;
         end
      end
   end

   always_comb begin
      win     = '0;
      any_rem = 1'b0;
      for (int v = N_VEC - 1; v >= 0; v--) begin
         if (rem_req[v]) begin
            win     = VEC_W'(v);
            any_rem = 1'b1;
         end
      end
      rem_clr = '0;
      if (any_rem)
         rem_clr[win] = 1'b1;
   end

   assign remote_vld  = any_rem;
   assign remote_vec  = win;
   assign remote_node = any_rem ? route_flat[32'(win)*LANE_W + 4 +: 4] : 4'd0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= '0;
         pend  <= '0;
      end else begin
         vec_q <= vec_in;
         pend  <= (pend & ~(go_loc | rem_clr)) | (vec_in & ~vec_q);
      end
   end
endmodule

// File: rtl/vir_core_status.sv
module vir_core_status
   import vir_pkg::*;
#(
   parameter int N_VEC  = 256,
   parameter int N_LINE = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [N_VEC-1:0]                   set_v,
   input  logic [N_VEC-1:0]                   clr_v,
   input  logic [N_VEC-1:0]                   en_vec,
   input  logic                               gen_en,
   input  logic [(N_VEC/GRP_SZ)*LANE_W-1:0]   pmap_flat,
   output logic [N_VEC-1:0]                   st,
   output logic [N_LINE-1:0]                  lines
);
   always_ff @(posedge clk) begin
      if (!rst_n) st <= '0;
      else        st <= (st & ~clr_v) | set_v;
   end

   always_comb begin
      logic acc;
      for (int k = 0; k < N_LINE; k++) begin
         acc = 1'b0;
         for (int v = 0; v < N_VEC; v++)
            acc = acc | (st[v] & en_vec[v] & pmap_flat[(v/GRP_SZ)*LANE_W + k]);
         lines[k] = gen_en & acc;
      end
   end
endmodule

// File: rtl/vec_irq_router.sv
module vec_irq_router
   import vir_pkg::*;
#(
   parameter int N_VEC      = 256,
   parameter int N_CORE     = 4,
   parameter int N_LINE     = 8,
   parameter int LOCAL_NODE = 0,
   parameter int RST_LINE   = 1,
   parameter int ADDR_W     = 8,
   localparam int VEC_W     = $clog2(N_VEC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_VEC-1:0]         vec_in,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [31:0]              reg_wdata,
   input  logic [3:0]               reg_wstrb,
   output logic [31:0]              reg_rdata,
   output logic [N_CORE*N_LINE-1:0] irq_lines,
   output logic                     remote_vld,
   output logic [3:0]               remote_node,
   output logic [VEC_W-1:0]         remote_vec
);
   localparam int N_GRP = N_VEC / GRP_SZ;

   if (N_VEC < GRP_SZ || N_VEC % GRP_SZ != 0) begin : g_bad_vec
      $error("vec_irq_router: N_VEC must be a multiple of 32");
   end
   if (N_CORE < 1 || N_CORE > MAX_CORE) begin : g_bad_core
      $error("vec_irq_router: N_CORE must be 1..4");
   end
   if (N_LINE < 1 || N_LINE > MAX_LINE) begin : g_bad_line
      $error("vec_irq_router: N_LINE must be 1..8");
   end
   if (RST_LINE >= N_LINE || LOCAL_NODE > 15) begin : g_bad_rst
      $error("vec_irq_router: reset line or node out of range");
   end

   logic                      gen_en;
   logic [N_VEC-1:0]          en_vec;
   logic [N_VEC-1:0]          bnc_vec;
   logic [N_VEC*LANE_W-1:0]   route_flat;
   logic [N_GRP*LANE_W-1:0]   pmap_flat;
   logic [N_CORE*N_VEC-1:0]   st_flat;
   logic [N_CORE*N_VEC-1:0]   clr_flat;
   logic [N_CORE*N_VEC-1:0]   set_flat;
   logic [N_VEC-1:0]          pend;

   vir_regs #(
      .N_VEC(N_VEC), .N_CORE(N_CORE), .LOCAL_NODE(LOCAL_NODE),
      .RST_LINE(RST_LINE), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata),
      .st_flat(st_flat), .clr_flat(clr_flat),
      .gen_en(gen_en), .en_vec(en_vec), .bnc_vec(bnc_vec),
      .route_flat(route_flat), .pmap_flat(pmap_flat)
   );

   vir_deliver #(
      .N_VEC(N_VEC), .N_CORE(N_CORE), .LOCAL_NODE(LOCAL_NODE)
   ) u_deliver (
      .clk(clk), .rst_n(rst_n), .vec_in(vec_in),
      .gen_en(gen_en), .en_vec(en_vec), .bnc_vec(bnc_vec),
      .route_flat(route_flat), .set_flat(set_flat), .pend(pend),
      .remote_vld(remote_vld), .remote_node(remote_node), .remote_vec(remote_vec)
   );

   for (genvar c = 0; c < N_CORE; c++) begin : g_core
      vir_core_status #(
         .N_VEC(N_VEC), .N_LINE(N_LINE)
      ) u_status (
         .clk(clk), .rst_n(rst_n),
         .set_v(set_flat[c*N_VEC +: N_VEC]),
         .clr_v(clr_flat[c*N_VEC +: N_VEC]),
         .en_vec(en_vec), .gen_en(gen_en), .pmap_flat(pmap_flat),
         .st(st_flat[c*N_VEC +: N_VEC]),
         .lines(irq_lines[c*N_LINE +: N_LINE])
      );
   end
endmodule

// File: rtl/vir_checker.sv
module vir_checker #(
   parameter int N_VEC      = 256,
   parameter int N_CORE     = 4,
   parameter int N_LINE     = 8,
   parameter int LOCAL_NODE = 0,
   localparam int VEC_W     = $clog2(N_VEC)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     gen_en,
   input logic                     remote_vld,
   input logic [3:0]               remote_node,
   input logic [VEC_W-1:0]         remote_vec,
   input logic [N_VEC-1:0]         pend,
   input logic [N_CORE*N_VEC-1:0]  st_flat,
   input logic [N_CORE*N_LINE-1:0] irq_lines
);
   assert_remote_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remote_vld |-> (remote_node != 4'(LOCAL_NODE)));

   assert_remote_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remote_vld |-> pend[remote_vec]);

   assert_lines_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (irq_lines == '0));

   for (genvar c = 0; c < N_CORE; c++) begin : g_core_chk
      assert_line_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (|irq_lines[c*N_LINE +: N_LINE]) |-> (|st_flat[c*N_VEC +: N_VEC]));
   end
endmodule

bind vec_irq_router vir_checker #(
   .N_VEC(N_VEC), .N_CORE(N_CORE), .N_LINE(N_LINE), .LOCAL_NODE(LOCAL_NODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
   .remote_vld(remote_vld), .remote_node(remote_node), .remote_vec(remote_vec),
   .pend(pend), .st_flat(st_flat), .irq_lines(irq_lines)
);

// File: tb/vec_irq_router_tb.sv
module vec_irq_router_tb;
   localparam int NV = 64;
   localparam int NC = 4;
   localparam int NL = 8;
   localparam int LN = 3;
   localparam int AW = 5;
   localparam int VW = $clog2(NV);
   localparam int NG = NV / 32;
   localparam int CTRL = 0;
   localparam int PMAP = 1;
   localparam int EN   = PMAP + (NG + 3) / 4;
   localparam int BNC  = EN + NG;
   localparam int RT   = BNC + NG;
   localparam int ST   = RT + NV / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NV-1:0]    vec = '0;
   logic             wr = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [31:0]      wdata = '0;
   logic [3:0]       wstrb = '0;
   logic [31:0]      rdata;
   logic [NC*NL-1:0] lines;
   logic             rvld;
   logic [3:0]       rnode;
   logic [VW-1:0]    rvec;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [7:0] rmod [NV];

   vec_irq_router #(
      .N_VEC(NV), .N_CORE(NC), .N_LINE(NL), .LOCAL_NODE(LN), .RST_LINE(1), .ADDR_W(AW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .vec_in(vec),
      .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_wstrb(wstrb),
      .reg_rdata(rdata), .irq_lines(lines),
      .remote_vld(rvld), .remote_node(rnode), .remote_vec(rvec)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(int a, logic [31:0] d, logic [3:0] s);
      @(negedge clk);
      wr = 1'b1; addr = AW'(a); wdata = d; wstrb = s;
      @(negedge clk);
      wr = 1'b0; wstrb = '0;
   endtask

   task automatic rd_reg(int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      #1 d = rdata;
   endtask

   task automatic pulse(int v);
      @(negedge clk); vec[v] = 1'b1;
      @(negedge clk); vec[v] = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [3:0] targets(logic [7:0] rb, bit bnc);
      logic [3:0] bmp = rb[3:0];
      if (!bnc) return bmp;
      for (int i = 0; i < 4; i++)
         if (bmp[i]) return 4'(1 << i);
      return 4'd0;
   endfunction

   function automatic logic [31:0] exp_lines(logic [3:0] cores, int line);
      logic [31:0] r = '0;
      for (int c = 0; c < NC; c++)
         if (cores[c]) r[c*NL + line] = 1'b1;
      return r;
   endfunction

   task automatic set_route(int v, logic [7:0] b);
      int lane = v % 4;
      rmod[v] = b;
      wr_reg(RT + v/4, 32'(b) << (8*lane), 4'(1 << lane));
   endtask

   task automatic st_check(int v, logic [3:0] cores, string tag);
      logic [31:0] d;
      for (int c = 0; c < NC; c++) begin
         rd_reg(ST + c*NG + v/32, d);
         check($sformatf("%s v=%0d core=%0d", tag, v, c), d,
               cores[c] ? (32'h1 << (v % 32)) : 32'h0);
      end
   endtask

   task automatic st_clear(int v, logic [3:0] cores);
      for (int c = 0; c < NC; c++)
         if (cores[c]) wr_reg(ST + c*NG + v/32, 32'h1 << (v % 32), 4'hF);
   endtask

   function automatic int grp_line(int v);
      return (v / 32 == 0) ? 5 : 1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] expw;
      logic [3:0]  t;
      for (int v = 0; v < NV; v++) rmod[v] = {4'(LN), 4'b0001};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(CTRL, d); check("R1 ctrl", d, 0);
      rd_reg(PMAP, d); check("R1 map", d, 32'h0000_0202);
      for (int g = 0; g < NG; g++) begin
         rd_reg(EN + g, d);  check("R1 enable", d, 0);
         rd_reg(BNC + g, d); check("R1 bounce", d, 0);
      end
      rd_reg(RT, d);          check("R1 route first", d, 32'h3131_3131);
      rd_reg(RT + NV/4 - 1, d); check("R1 route last", d, 32'h3131_3131);
      for (int c = 0; c < NC; c++) begin
         rd_reg(ST + c*NG, d); check("R1 status", d, 0);
      end
      check("R1 lines", lines, 0);
      check("R1 remote", rvld, 0);

      // R2 configuration; pad map bytes ignored
      wr_reg(PMAP, 32'hFFFF_0220, 4'hF);
      rd_reg(PMAP, d); check("R2 map pad", d, 32'h0000_0220);
      for (int g = 0; g < NG; g++) begin
         wr_reg(EN + g, 32'hFFFF_FFFF, 4'hF);
         wr_reg(BNC + g, 32'hAAAA_AAAA, 4'hF);
      end
      wr_reg(CTRL, 32'h1, 4'h1);

      // R3 R4 R5 R10 sweep of every vector, R2 byte lanes on route words
      for (int v = 0; v < NV; v++) begin
         set_route(v, 8'(8'h30 | ((v % 15) + 1)));
         rd_reg(RT + v/4, d);
         expw = {rmod[(v/4)*4+3], rmod[(v/4)*4+2], rmod[(v/4)*4+1], rmod[(v/4)*4]};
         check($sformatf("R2 route lanes v=%0d", v), d, expw);
         t = targets(rmod[v], v % 2 == 1);
         pulse(v);
         st_check(v, t, (v % 2 == 1) ? "R5 bounce" : "R4 broadcast");
         check($sformatf("R10 lines v=%0d", v), lines, exp_lines(t, grp_line(v)));
         st_clear(v, t);
         #1 check($sformatf("R9 cleared lines v=%0d", v), lines, 0);
      end

      // R6 masked during reroute
      wr_reg(EN, ~(32'h1 << 5), 4'hF);
      pulse(5);
      st_check(5, 4'b0000, "R6 masked");
      check("R6 masked lines", lines, 0);
      set_route(5, 8'h38);
      wr_reg(EN, 32'hFFFF_FFFF, 4'hF);
      @(negedge clk);
      st_check(5, 4'b1000, "R6 rerouted");
      check("R10 rerouted lines", lines, exp_lines(4'b1000, 5));
      st_clear(5, 4'b1000);

      // R6 global enable off
      wr_reg(CTRL, 32'h0, 4'h1);
      pulse(40);
      repeat (2) @(negedge clk);
      st_check(40, 4'b0000, "R6 global off");
      check("R10 global off lines", lines, 0);
      wr_reg(CTRL, 32'h1, 4'h1);
      @(negedge clk);
      st_check(40, 4'b1011, "R6 global on");
      check("R10 global on lines", lines, exp_lines(4'b1011, 1));
      st_clear(40, 4'b1011);

      // R7 empty bitmap stays pending
      set_route(2, 8'h30);
      pulse(2);
      st_check(2, 4'b0000, "R7 empty");
      set_route(2, 8'h34);
      @(negedge clk);
      st_check(2, 4'b0100, "R7 later route");
      st_clear(2, 4'b0100);

      // R8 remote strobes, lowest vector first
      set_route(12, 8'h71);
      set_route(20, 8'h91);
      @(negedge clk); vec[12] = 1'b1; vec[20] = 1'b1;
      @(negedge clk); vec[12] = 1'b0; vec[20] = 1'b0;
      #1;
      check("R8 first vld", rvld, 1);
      check("R8 first vec", rvec, 12);
      check("R8 first node", rnode, 7);
      @(negedge clk); #1;
      check("R8 second vld", rvld, 1);
      check("R8 second vec", rvec, 20);
      check("R8 second node", rnode, 9);
      @(negedge clk); #1;
      check("R8 idle", rvld, 0);
      st_check(12, 4'b0000, "R8 no local");
      st_check(20, 4'b0000, "R8 no local");

      // R9 clear and set on the same edge
      set_route(9, 8'h38);
      @(negedge clk); vec[7] = 1'b1; vec[9] = 1'b1;
      @(negedge clk); vec[7] = 1'b0; vec[9] = 1'b0;
      @(negedge clk);
      rd_reg(ST + 3*NG, d); check("R9 both set", d, 32'h280);
      @(negedge clk); vec[7] = 1'b1;
      @(negedge clk); vec[7] = 1'b0;
      wr = 1'b1; addr = AW'(ST + 3*NG); wdata = 32'h280; wstrb = 4'hF;
      @(negedge clk); wr = 1'b0; wstrb = '0;
      rd_reg(ST + 3*NG, d); check("R9 set wins", d, 32'h80);
      check("R9 line kept", lines, exp_lines(4'b1000, 5));
      st_clear(7, 4'b1000);

      // R3 held level does not pend again
      @(negedge clk); vec[30] = 1'b1;
      repeat (2) @(negedge clk);
      rd_reg(ST, d); check("R3 edge delivered", d, 32'h1 << 30);
      wr_reg(ST, 32'h1 << 30, 4'hF);
      repeat (3) @(negedge clk);
      rd_reg(ST, d); check("R3 level no retrigger", d, 0);
      vec[30] = 1'b0;

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule